// File: doc/BRIEF.md
# Packet Write Commit Queue

This block sits beside the execute stage of a wide-issue core. While the instructions of one issue packet execute, their architectural results are not written at once. Each result enters this queue instead, as a register write, a PC write or a function-PC write. Every entry carries the address of the instruction that produced it and a force flag. When the packet ends, a single commit strobe replays the queue one entry per cycle, in the order the entries arrived. The replayed register writes go out on a register-file write port.

During the replay, a pending imprecise exception can suppress results from the faulting instruction. Only the first surviving branch decides the next PC. A call that asked for a link gets the sequential PC written to the link register. When the replay ends, the block publishes the resolved next PC, pulses `done`, and leaves the queue empty for the next packet.

Top module: `pkt_write_commit`

## Requirements
- R1: After reset, `busy`, `done`, `ovf` and `rf_we` are 0, and `next_pc` and `prev_pc` are 0.
- R2: A `pkt_start` accepted while idle empties the queue, clears `ovf`, and makes `prev_pc` equal to `pc_in` from the following cycle. While idle, `pkt_start` has priority over `commit`, and `commit` has priority over an enqueue.
- R3: An enqueue while the queue already holds DEPTH entries is dropped and sets `ovf`. `ovf` stays set until the next accepted `pkt_start`.
- R4: Entries are replayed in enqueue order, one per cycle, starting in the cycle after `commit`. A surviving entry of kind 0 (register write) drives `rf_we` high with `rf_addr` equal to its target and `rf_data` equal to its value.
- R5: Kinds 1 (PC write) and 2 (function-PC write) are branches. Only the first surviving branch sets the next PC, and later branches in the packet are discarded. Kind 3 writes nothing.
- R6: If no branch survives, `next_pc` becomes the `pc_in` sampled with `commit`.
- R7: Exception inputs are sampled with `commit`. When `exc_valid` is set, only entries whose instruction address equals `exc_iaddr` are filtered, and all other entries are applied.
- R8: For a floating-point exception (`exc_fp`=1), a filtered entry is applied only if `exc_mask` has no bit set outside bits 0 to 2. Those bits are inexact (bit 0), overflow (bit 1) and underflow (bit 2). Bit 3 is divide-by-zero and bit 4 is invalid.
- R9: For any other exception, a filtered entry is applied only if its force flag is 1.
- R10: `rpt_pc` shows the instruction address of the entry being replayed in each replay cycle, and shows `next_pc` otherwise.
- R11: A `link_set` seen while idle marks a link as pending. In the cycle after the last replayed entry, a pending link writes `pc_in` saved at commit to register LINK_IDX, and the mark is then cleared.
- R12: With N entries, `busy` is high for N+1 cycles and `done` pulses for exactly one cycle after that, together with the updated `next_pc`. `pkt_start`, `commit`, enqueues and `link_set` are ignored while `busy`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pkt_start | input | 1 | Start of a new packet |
| pc_in | input | W | Packet PC at start, sequential PC at commit |
| enq_valid | input | 1 | Enqueue strobe |
| enq_kind | input | 2 | 0 register, 1 PC, 2 function-PC, 3 none |
| enq_iaddr | input | W | Address of the issuing instruction |
| enq_force | input | 1 | Force flag |
| enq_tgt | input | RW | Register target |
| enq_data | input | W | Value to write |
| link_set | input | 1 | Request link-register update at commit |
| commit | input | 1 | Commit strobe |
| exc_valid | input | 1 | Imprecise exception pending |
| exc_fp | input | 1 | Exception is floating point |
| exc_mask | input | 5 | FP status bits of the exception |
| exc_iaddr | input | W | Faulting instruction address |
| busy | output | 1 | Commit in progress |
| ovf | output | 1 | Sticky enqueue overflow |
| rf_we | output | 1 | Register-file write enable |
| rf_addr | output | RW | Register-file write index |
| rf_data | output | W | Register-file write data |
| rpt_pc | output | W | PC reported for fault context |
| next_pc | output | W | Resolved PC after last commit |
| prev_pc | output | W | PC latched at packet start |
| done | output | 1 | One-cycle commit completion pulse |

## Verification
A corrupted fill count or read index shows at the ports within one replay cycle. It appears as a missing, duplicated or reordered register write, or as a `rpt_pc` that names the wrong instruction. A stuck branch-taken bit or a wrong saved PC stays hidden until the `done` cycle, where `next_pc` or the link write disagrees with the expected value. Wrong exception sampling shows up only on entries whose address matches the faulting one. For that reason, the filtered cases combine matching and non-matching addresses in the same packet.

// File: rtl/pkt_write_commit.sv
module pkt_write_commit #(
  parameter int DEPTH    = 16,
  parameter int W        = 32,
  parameter int RW       = 6,
  parameter int LINK_IDX = 63
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pkt_start,
  input  logic [W-1:0]  pc_in,
  input  logic          enq_valid,
  input  logic [1:0]    enq_kind,
  input  logic [W-1:0]  enq_iaddr,
  input  logic          enq_force,
  input  logic [RW-1:0] enq_tgt,
  input  logic [W-1:0]  enq_data,
  input  logic          link_set,
  input  logic          commit,
  input  logic          exc_valid,
  input  logic          exc_fp,
  input  logic [4:0]    exc_mask,
  input  logic [W-1:0]  exc_iaddr,
  output logic          busy,
  output logic          ovf,
  output logic          rf_we,
  output logic [RW-1:0] rf_addr,
  output logic [W-1:0]  rf_data,
  output logic [W-1:0]  rpt_pc,
  output logic [W-1:0]  next_pc,
  output logic [W-1:0]  prev_pc,
  output logic          done
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [1:0] K_REG = 2'd0;
  localparam logic [1:0] K_PC  = 2'd1;
  localparam logic [1:0] K_FPC = 2'd2;
  localparam logic [4:0] FP_BENIGN = 5'b00111;

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_FIN} st_t;

  logic [1:0]    q_kind [DEPTH];
  logic [W-1:0]  q_ia   [DEPTH];
  logic          q_frc  [DEPTH];
  logic [RW-1:0] q_tgt  [DEPTH];
  logic [W-1:0]  q_val  [DEPTH];

  st_t          st;
  logic [CW-1:0] cnt, idx;
  logic          link_q, taken, done_q, ovf_q;
  logic          xv, xfp;
  logic [4:0]    xmask;
  logic [W-1:0]  xia, save_pc, new_pc, pc_q, prev_q;

  wire [IW-1:0] rd     = idx[IW-1:0];
  wire          idle   = (st == S_IDLE);
  wire          run    = (st == S_RUN);
  wire          fin    = (st == S_FIN);
  wire          full   = (cnt == CW'(DEPTH));
  wire          do_enq = idle && !pkt_start && !commit && enq_valid;
  wire          hit    = xv && (q_ia[rd] == xia);
  wire          ok     = !hit || (xfp ? ((xmask & ~FP_BENIGN) == 5'd0) : q_frc[rd]);
  wire          is_br  = (q_kind[rd] == K_PC) || (q_kind[rd] == K_FPC);
  wire          wr_reg = run && ok && (q_kind[rd] == K_REG);
  wire          take   = run && ok && is_br && !taken;

  assign busy    = !idle;
  assign ovf     = ovf_q;
  assign done    = done_q;
  assign next_pc = pc_q;
  assign prev_pc = prev_q;
  assign rf_we   = wr_reg || (fin && link_q);
  assign rf_addr = fin ? RW'(LINK_IDX) : q_tgt[rd];
  assign rf_data = fin ? save_pc : q_val[rd];
  assign rpt_pc  = run ? q_ia[rd] : pc_q;

  always_ff @(posedge clk) begin
    if (do_enq && !full) begin
      q_kind[cnt[IW-1:0]] <= enq_kind;
      q_ia[cnt[IW-1:0]]   <= enq_iaddr;
      q_frc[cnt[IW-1:0]]  <= enq_force;
      q_tgt[cnt[IW-1:0]]  <= enq_tgt;
      q_val[cnt[IW-1:0]]  <= enq_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cnt     <= '0;
      idx     <= '0;
      link_q  <= 1'b0;
      taken   <= 1'b0;
      done_q  <= 1'b0;
      ovf_q   <= 1'b0;
      xv      <= 1'b0;
      xfp     <= 1'b0;
      xmask   <= '0;
      xia     <= '0;
      save_pc <= '0;
      new_pc  <= '0;
      pc_q    <= '0;
      prev_q  <= '0;
    end else begin
      done_q <= 1'b0;
      case (st)
        S_IDLE: begin
          if (link_set) link_q <= 1'b1;
          if (pkt_start) begin
            cnt    <= '0;
            ovf_q  <= 1'b0;
            prev_q <= pc_in;
          end else if (commit) begin
            xv      <= exc_valid;
            xfp     <= exc_fp;
            xmask   <= exc_mask;
            xia     <= exc_iaddr;
            save_pc <= pc_in;
            new_pc  <= pc_in;
            taken   <= 1'b0;
            idx     <= '0;
            st      <= (cnt == '0) ? S_FIN : S_RUN;
          end else if (enq_valid) begin
            if (full) ovf_q <= 1'b1;
            else      cnt   <= cnt + 1'b1;
          end
        end
        S_RUN: begin
          if (take) begin
            taken  <= 1'b1;
            new_pc <= q_val[rd];
          end
          idx <= idx + 1'b1;
          if (idx == cnt - 1'b1) st <= S_FIN;
        end
        default: begin
          pc_q   <= new_pc;
          cnt    <= '0;
          link_q <= 1'b0;
          done_q <= 1'b1;
          st     <= S_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/pkt_write_commit_chk.sv
module pkt_write_commit_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         pkt_start,
  input logic         commit,
  input logic         busy,
  input logic         done,
  input logic         ovf,
  input logic         rf_we,
  input logic [W-1:0] next_pc,
  input logic [W-1:0] prev_pc
);
  p_done_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_we_in_commit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> busy);

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !(pkt_start && !busy)) |=> ovf);

  p_pc_moves_at_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(next_pc) |-> done);

  p_commit_starts_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !busy && !pkt_start) |=> busy);

  p_prev_after_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(prev_pc) |-> $past(pkt_start));
endmodule

bind pkt_write_commit pkt_write_commit_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pkt_start(pkt_start), .commit(commit),
  .busy(busy), .done(done), .ovf(ovf), .rf_we(rf_we),
  .next_pc(next_pc), .prev_pc(prev_pc)
);

// File: tb/pkt_write_commit_test.sv
`timescale 1ns/1ps
module pkt_write_commit_test;
  localparam int D = 8;
  localparam int LNK = 63;

  logic clk = 0, rst_n = 0;
  logic pkt_start = 0, enq_valid = 0, enq_force = 0, link_set = 0, commit = 0;
  logic exc_valid = 0, exc_fp = 0;
  logic [4:0] exc_mask = 0;
  logic [1:0] enq_kind = 0;
  logic [5:0] enq_tgt = 0;
  logic [31:0] pc_in = 0, enq_iaddr = 0, enq_data = 0, exc_iaddr = 0;
  logic busy, ovf, rf_we, done;
  logic [5:0] rf_addr;
  logic [31:0] rf_data, rpt_pc, next_pc, prev_pc;

  always #10 clk = ~clk;

  pkt_write_commit #(.DEPTH(D), .W(32), .RW(6), .LINK_IDX(LNK)) uut (
    .clk(clk), .rst_n(rst_n), .pkt_start(pkt_start), .pc_in(pc_in),
    .enq_valid(enq_valid), .enq_kind(enq_kind), .enq_iaddr(enq_iaddr),
    .enq_force(enq_force), .enq_tgt(enq_tgt), .enq_data(enq_data),
    .link_set(link_set), .commit(commit), .exc_valid(exc_valid),
    .exc_fp(exc_fp), .exc_mask(exc_mask), .exc_iaddr(exc_iaddr),
    .busy(busy), .ovf(ovf), .rf_we(rf_we), .rf_addr(rf_addr),
    .rf_data(rf_data), .rpt_pc(rpt_pc), .next_pc(next_pc),
    .prev_pc(prev_pc), .done(done));

  int total = 0, bad = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  typedef struct {logic [1:0] k; logic [31:0] ia; logic f; logic [5:0] t; logic [31:0] v;} ent_t;
  typedef struct {logic bz, we, dn; logic [5:0] a; logic [31:0] d, rpt, nxt;} cyc_t;
  ent_t mq[$];
  cyc_t sched[$];
  cyc_t cur;
  logic m_ovf = 0, m_pend = 0;
  logic [31:0] m_pc = 0, m_prev = 0;

  function automatic cyc_t idle_cyc(logic [31:0] pc);
    cyc_t c;
    c.bz = 0; c.we = 0; c.dn = 0; c.a = 0; c.d = 0; c.rpt = pc; c.nxt = pc;
    return c;
  endfunction

  initial cur = idle_cyc(0);

  always @(posedge clk) begin
    if (!rst_n) begin
      mq.delete(); sched.delete();
      m_ovf = 0; m_pend = 0; m_pc = 0; m_prev = 0;
      cur = idle_cyc(0);
    end else begin
      if (!cur.bz) begin
        if (link_set) m_pend = 1;
        if (pkt_start) begin
          mq.delete(); m_ovf = 0; m_prev = pc_in;
        end else if (commit) begin
          logic br; logic [31:0] nx; cyc_t c;
          br = 0; nx = pc_in;
          foreach (mq[i]) begin
            logic keep;
            keep = !(exc_valid && mq[i].ia == exc_iaddr) ||
                   (exc_fp ? (exc_mask[4:3] == 2'b00) : mq[i].f);
            c.bz = 1; c.dn = 0; c.rpt = mq[i].ia; c.nxt = m_pc;
            c.we = keep && mq[i].k == 2'd0; c.a = mq[i].t; c.d = mq[i].v;
            if (keep && (mq[i].k == 2'd1 || mq[i].k == 2'd2) && !br) begin
              br = 1; nx = mq[i].v;
            end
            sched.push_back(c);
          end
          c.bz = 1; c.dn = 0; c.we = m_pend; c.a = 6'(LNK); c.d = pc_in;
          c.rpt = m_pc; c.nxt = m_pc;
          sched.push_back(c);
          c.bz = 0; c.we = 0; c.dn = 1; c.rpt = nx; c.nxt = nx;
          sched.push_back(c);
          m_pend = 0;
          mq.delete();
        end else if (enq_valid) begin
          ent_t e;
          if (mq.size() < D) begin
            e.k = enq_kind; e.ia = enq_iaddr; e.f = enq_force; e.t = enq_tgt; e.v = enq_data;
            mq.push_back(e);
          end else m_ovf = 1;
        end
      end
      if (sched.size() > 0) cur = sched.pop_front();
      else cur = idle_cyc(m_pc);
      if (cur.dn) m_pc = cur.nxt;
    end
  end

  logic [5:0]  la[$];
  logic [31:0] ld[$];

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R12 busy", 32'(busy), 32'(cur.bz));
      chk("R12 done", 32'(done), 32'(cur.dn));
      chk("R3 ovf", 32'(ovf), 32'(m_ovf));
      chk("R4 rf_we", 32'(rf_we), 32'(cur.we));
      if (cur.we && rf_we) begin
        chk("R4 rf_addr", 32'(rf_addr), 32'(cur.a));
        chk("R4 rf_data", rf_data, cur.d);
      end
      chk("R10 rpt_pc", rpt_pc, cur.rpt);
      chk("R6 next_pc", next_pc, cur.nxt);
      chk("R2 prev_pc", prev_pc, m_prev);
      if (rf_we) begin la.push_back(rf_addr); ld.push_back(rf_data); end
    end
  end

  task automatic start_pkt(logic [31:0] pc);
    pkt_start = 1; pc_in = pc;
    @(negedge clk);
    pkt_start = 0;
  endtask

  task automatic enq(logic [1:0] k, logic [31:0] ia, logic f, logic [5:0] t, logic [31:0] v);
    enq_valid = 1; enq_kind = k; enq_iaddr = ia; enq_force = f; enq_tgt = t; enq_data = v;
    @(negedge clk);
    enq_valid = 0;
  endtask

  task automatic do_commit(logic [31:0] pc, logic xv, logic xf, logic [4:0] xm,
                           logic [31:0] xa, output int cyc);
    la.delete(); ld.delete();
    commit = 1; pc_in = pc; exc_valid = xv; exc_fp = xf; exc_mask = xm; exc_iaddr = xa;
    cyc = 0;
    @(negedge clk);
    commit = 0; exc_valid = 0; exc_fp = 0; exc_mask = 0; exc_iaddr = 0;
    cyc = 1;
    while (!done && cyc < 60) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic load_exc_set();
    start_pkt(32'h300);
    enq(0, 32'h300, 0, 1, 32'h1);
    enq(0, 32'h300, 1, 2, 32'h2);
    enq(0, 32'h304, 0, 3, 32'h3);
    enq(1, 32'h300, 0, 0, 32'h999);
    enq(1, 32'h304, 0, 0, 32'h500);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int c;
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 busy", 32'(busy), 0); chk("R1 done", 32'(done), 0);
    chk("R1 ovf", 32'(ovf), 0); chk("R1 rf_we", 32'(rf_we), 0);
    chk("R1 next_pc", next_pc, 0); chk("R1 prev_pc", prev_pc, 0);

    start_pkt(32'h100);
    chk("R2 prev_pc", prev_pc, 32'h100);
    enq(0, 32'h100, 0, 3, 32'hAA);
    enq(1, 32'h104, 0, 0, 32'h400);
    enq(0, 32'h108, 0, 5, 32'hBB);
    enq(2, 32'h10C, 0, 0, 32'h800);
    enq(3, 32'h110, 0, 7, 32'hCC);
    do_commit(32'h114, 0, 0, 0, 0, c);
    chk("R12 cycles to done", 32'(c), 7);
    chk("R4 write count", 32'(la.size()), 2);
    if (la.size() == 2) begin
      chk("R4 first tgt", 32'(la[0]), 3); chk("R4 first val", ld[0], 32'hAA);
      chk("R4 second tgt", 32'(la[1]), 5); chk("R4 second val", ld[1], 32'hBB);
    end
    chk("R5 first branch wins", next_pc, 32'h400);

    link_set = 1; @(negedge clk); link_set = 0;
    start_pkt(32'h200);
    enq(0, 32'h200, 0, 9, 32'h11);
    do_commit(32'h204, 0, 0, 0, 0, c);
    chk("R6 sequential pc", next_pc, 32'h204);
    chk("R11 write count", 32'(la.size()), 2);
    if (la.size() == 2) begin
      chk("R11 link tgt", 32'(la[1]), LNK); chk("R11 link val", ld[1], 32'h204);
    end
    do_commit(32'h300, 0, 0, 0, 0, c);
    chk("R11 link cleared", 32'(la.size()), 0);
    chk("R12 empty commit cycles", 32'(c), 2);

    load_exc_set();
    do_commit(32'h310, 1, 0, 0, 32'h300, c);
    chk("R9 write count", 32'(la.size()), 2);
    if (la.size() == 2) begin
      chk("R9 forced kept", 32'(la[0]), 2); chk("R7 other insn kept", 32'(la[1]), 3);
    end
    chk("R5 filtered branch skipped", next_pc, 32'h500);

    load_exc_set();
    do_commit(32'h310, 1, 1, 5'b00011, 32'h300, c);
    chk("R8 benign fp count", 32'(la.size()), 3);
    chk("R8 benign fp branch", next_pc, 32'h999);

    load_exc_set();
    do_commit(32'h310, 1, 1, 5'b01001, 32'h300, c);
    chk("R8 severe fp count", 32'(la.size()), 1);
    chk("R8 severe fp branch", next_pc, 32'h500);

    start_pkt(32'h600);
    for (int i = 1; i <= D + 1; i++) enq(0, 32'h600, 0, 6'(i), 32'(i));
    chk("R3 ovf set", 32'(ovf), 1);
    do_commit(32'h640, 0, 0, 0, 0, c);
    chk("R3 kept count", 32'(la.size()), D);
    if (la.size() == D) chk("R3 last kept", ld[D-1], D);
    chk("R3 ovf sticky", 32'(ovf), 1);
    start_pkt(32'h700);
    chk("R2 ovf cleared", 32'(ovf), 0);
    chk("R2 prev latched", prev_pc, 32'h700);

    enq(0, 32'h700, 0, 4, 32'h44);
    la.delete(); ld.delete();
    commit = 1; pc_in = 32'h710;
    @(negedge clk);
    commit = 0;
    enq_valid = 1; enq_kind = 0; enq_tgt = 20; enq_data = 32'h55;
    pkt_start = 1; pc_in = 32'h9999;
    @(negedge clk);
    enq_valid = 0; pkt_start = 0;
    while (!done) @(negedge clk);
    chk("R12 prev unchanged while busy", prev_pc, 32'h700);
    do_commit(32'h720, 0, 0, 0, 0, c);
    chk("R12 busy enqueue ignored", 32'(la.size()), 0);

    repeat (3) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule